// File: doc/BRIEF.md
# Key-protected power control registers

This block is a small register slave for a plain bus with an address, write data, a write strobe and a combinational read-data return. It holds the chip's power-mode setting, two autosleep enables, a low-frequency system-clock select and a small low-power control word. It drives each of these straight to the rest of the chip. Gating power, switching clocks and running oscillators, sleep timers or sequencers are left to other blocks.

Two different protection schemes guard the registers. The power-mode register accepts a write only straight after an ordered two-word unlock sequence, written to a 16-bit sequence-key register. Any other register write in between closes the sequence again. The clock-select and low-power control registers work differently. They accept writes only while a separate 20-bit level key holds one specific value, and that key stays open until software overwrites it.

Register map (byte offsets): 0x00 power mode, 0x04 sequence key, 0x08 level key, 0x0C clock select, 0x10 low-power control. Reads at any other offset return 0.

Top module: `pwr_key_ctrl`

## Requirements
- R1: After reset the mode is 01 (active), both autosleep enables are 0, the clock select is 0, the low-power control word is 0, the level key is locked, and a power-mode read returns 0x1.
- R2: The sequence key is written at 0x04 and compared on wdata[15:0]. Writing 0x4859 and then 0xF27B, followed directly by a power-mode write at 0x00, loads the mode from wdata[1:0], the timer autosleep enable from wdata[2] and the sequencer autosleep enable from wdata[3].
- R3: A power-mode write made while the sequence is not complete is ignored, and the register keeps its value.
- R4: Once the sequence is complete, a write to any other address, including an unmapped one, locks the sequence again, so a power-mode write that follows is ignored.
- R5: Within the sequence, writing 0x4859 again restarts it at the second step. Writing 0xF27B first, or writing any other key value, locks the sequence.
- R6: A power-mode write accepted after the sequence locks the sequence again, so a second power-mode write without a new sequence is ignored.
- R7: A power-mode write whose wdata[1:0] is 11 (reserved) is dropped in full, autosleep bits included. It still locks the sequence.
- R8: Writes at 0x0C and 0x10 take effect only while the level key at 0x08 holds 0xC59D6 in wdata[19:0]; bits above 19 are ignored. Writing any other value locks those registers again, and writes made while locked are dropped.
- R9: Clock select is wdata[0] at 0x0C, where 1 selects the low-frequency oscillator. A read at 0x0C returns the select in bit 0 and zero in bits [31:1].
- R10: Reads at 0x04 and 0x08 always return 0.
- R11: A read at 0x00 returns the current mode in bits [1:0], the timer autosleep enable in bit 2 and the sequencer autosleep enable in bit 3, with the other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (8) | Byte address of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Read data for addr (combinational) |
| pwr_mode_o | output | 2 | Current power mode |
| tmr_sleep_en_o | output | 1 | Timer-driven autosleep enable |
| seq_sleep_en_o | output | 1 | Sequencer-driven autosleep enable |
| lf_clk_sel_o | output | 1 | 1 selects the low-frequency system clock |
| lp_ctrl_o | output | LPCTL_W (8) | Low-power control word |

## Verification
The hardest state to reach from the ports is a sequence that was opened and then silently closed: a half-open state where a repeated first key must count again, or an open state that is closed by a write to an unrelated or unmapped address. None of these states can be seen through a read, because the key registers read as zero. The stimulus table therefore walks key writes in restarted, reversed, corrupted and interrupted orders. Each case ends with a power-mode write, and that write's acceptance or rejection on the mode outputs shows which state the sequence was in.

// File: rtl/pwr_key_ctrl.sv
module pwr_key_ctrl #(
  parameter int          AW      = 8,
  parameter int          LPCTL_W = 8,
  parameter logic [15:0] PM_KEY1 = 16'h4859,
  parameter logic [15:0] PM_KEY2 = 16'hF27B,
  parameter logic [19:0] LP_KEY  = 20'hC59D6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic [31:0]        wdata,
  input  logic               wr_en,
  output logic [31:0]        rdata,
  output logic [1:0]         pwr_mode_o,
  output logic               tmr_sleep_en_o,
  output logic               seq_sleep_en_o,
  output logic               lf_clk_sel_o,
  output logic [LPCTL_W-1:0] lp_ctrl_o
);
  localparam logic [AW-1:0] A_PM     = AW'(8'h00);
  localparam logic [AW-1:0] A_PKEY   = AW'(8'h04);
  localparam logic [AW-1:0] A_LPKEY  = AW'(8'h08);
  localparam logic [AW-1:0] A_CLKSEL = AW'(8'h0C);
  localparam logic [AW-1:0] A_LPCTL  = AW'(8'h10);
  localparam logic [1:0]    MODE_ACTIVE = 2'b01;
  localparam logic [1:0]    MODE_RSVD   = 2'b11;

  typedef enum logic [1:0] {SEQ_LOCKED, SEQ_HALF, SEQ_OPEN} seq_t;

  seq_t               seq_q, seq_d;
  logic [19:0]        lpkey_q;
  logic [1:0]         mode_q;
  logic               tmr_q, sqs_q, cs_q;
  logic [LPCTL_W-1:0] lpc_q;
  logic               pm_open, lp_open;
  logic               unused_hi;

  wire wr_pm    = wr_en && (addr == A_PM);
  wire wr_pkey  = wr_en && (addr == A_PKEY);
  wire wr_lpkey = wr_en && (addr == A_LPKEY);
  wire wr_cs    = wr_en && (addr == A_CLKSEL);
  wire wr_lpc   = wr_en && (addr == A_LPCTL);

  assign pm_open   = (seq_q == SEQ_OPEN);
  assign lp_open   = (lpkey_q == LP_KEY);
  assign unused_hi = ^wdata[31:20];

  always_comb begin
    seq_d = seq_q;
    if (wr_pkey) begin
      if (wdata[15:0] == PM_KEY1)
        seq_d = SEQ_HALF;
      else if (wdata[15:0] == PM_KEY2 && seq_q == SEQ_HALF)
        seq_d = SEQ_OPEN;
      else
        seq_d = SEQ_LOCKED;
    end else if (wr_en) begin
      seq_d = SEQ_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= SEQ_LOCKED;
      mode_q  <= MODE_ACTIVE;
      tmr_q   <= 1'b0;
      sqs_q   <= 1'b0;
    end else begin
      seq_q <= seq_d;
      if (wr_pm && pm_open && wdata[1:0] != MODE_RSVD) begin
        mode_q <= wdata[1:0];
        tmr_q  <= wdata[2];
        sqs_q  <= wdata[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpkey_q <= '0;
      cs_q    <= 1'b0;
      lpc_q   <= '0;
    end else begin
      if (wr_lpkey)           lpkey_q <= wdata[19:0];
      if (wr_cs  && lp_open)  cs_q    <= wdata[0];
      if (wr_lpc && lp_open)  lpc_q   <= wdata[LPCTL_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_PM:     rdata = {28'd0, sqs_q, tmr_q, mode_q};
      A_CLKSEL: rdata = {31'd0, cs_q};
      A_LPCTL:  rdata = 32'(lpc_q);
      default:  rdata = '0;
    endcase
  end

  assign pwr_mode_o     = mode_q;
  assign tmr_sleep_en_o = tmr_q;
  assign seq_sleep_en_o = sqs_q;
  assign lf_clk_sel_o   = cs_q;
  assign lp_ctrl_o      = lpc_q;
endmodule

// File: rtl/pwr_key_ctrl_chk.sv
module pwr_key_ctrl_chk #(
  parameter int              AW = 8,
  parameter logic [AW-1:0]   A_PM = '0,
  parameter logic [AW-1:0]   A_PKEY = '0,
  parameter logic [AW-1:0]   A_LPKEY = '0,
  parameter logic [AW-1:0]   A_CLKSEL = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [31:0]   rdata,
  input logic [1:0]    pwr_mode_o,
  input logic          tmr_sleep_en_o,
  input logic          seq_sleep_en_o,
  input logic          lf_clk_sel_o,
  input logic          pm_open,
  input logic          lp_open
);
  // R3
  pm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_PM && pm_open) |=> $stable({seq_sleep_en_o, tmr_sleep_en_o, pwr_mode_o}));

  // R7
  no_rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode_o != 2'b11);

  // R4
  other_wr_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_PM && addr != A_PKEY) |=> !pm_open);

  // R6
  pm_wr_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PM) |=> !pm_open);

  // R8
  cs_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_CLKSEL && lp_open) |=> $stable(lf_clk_sel_o));

  // R10
  key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_PKEY || addr == A_LPKEY) |-> rdata == 32'd0);
endmodule

bind pwr_key_ctrl pwr_key_ctrl_chk #(
  .AW(AW), .A_PM(A_PM), .A_PKEY(A_PKEY), .A_LPKEY(A_LPKEY), .A_CLKSEL(A_CLKSEL)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rdata(rdata),
  .pwr_mode_o(pwr_mode_o), .tmr_sleep_en_o(tmr_sleep_en_o),
  .seq_sleep_en_o(seq_sleep_en_o), .lf_clk_sel_o(lf_clk_sel_o),
  .pm_open(pm_open), .lp_open(lp_open)
);

// File: tb/pwr_key_ctrl_tb_top.sv
module pwr_key_ctrl_tb_top;
  localparam int AW = 8;
  localparam int LW = 8;
  localparam int NV = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic wr_en = 1'b0;
  logic [31:0] rdata;
  logic [1:0] pwr_mode_o;
  logic tmr_sleep_en_o, seq_sleep_en_o, lf_clk_sel_o;
  logic [LW-1:0] lp_ctrl_o;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_key_ctrl #(.AW(AW), .LPCTL_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .pwr_mode_o(pwr_mode_o), .tmr_sleep_en_o(tmr_sleep_en_o),
    .seq_sleep_en_o(seq_sleep_en_o), .lf_clk_sel_o(lf_clk_sel_o), .lp_ctrl_o(lp_ctrl_o)
  );

  // {req[3:0], addr[7:0], wdata[31:0], exp {seq,tmr,mode}[3:0], exp clk select}
  localparam logic [48:0] VEC [NV] = '{
    {4'd3,  8'h00, 32'h0000_0006, 4'b0001, 1'b0}, // R3 locked write ignored
    {4'd2,  8'h04, 32'h0000_4859, 4'b0001, 1'b0},
    {4'd2,  8'h04, 32'h0000_F27B, 4'b0001, 1'b0},
    {4'd2,  8'h00, 32'h0000_000E, 4'b1110, 1'b0}, // R2 accepted
    {4'd6,  8'h00, 32'h0000_0001, 4'b1110, 1'b0}, // R6 relocked
    {4'd4,  8'h04, 32'h0000_4859, 4'b1110, 1'b0},
    {4'd4,  8'h04, 32'h0000_F27B, 4'b1110, 1'b0},
    {4'd8,  8'h0C, 32'h0000_0001, 4'b1110, 1'b0}, // R8 level key locked
    {4'd4,  8'h00, 32'h0000_0001, 4'b1110, 1'b0}, // R4 interposed write
    {4'd5,  8'h04, 32'h0000_F27B, 4'b1110, 1'b0},
    {4'd5,  8'h00, 32'h0000_0001, 4'b1110, 1'b0}, // R5 reversed order
    {4'd5,  8'h04, 32'h0000_4859, 4'b1110, 1'b0},
    {4'd5,  8'h04, 32'h0000_4859, 4'b1110, 1'b0},
    {4'd5,  8'h04, 32'h0000_F27B, 4'b1110, 1'b0},
    {4'd5,  8'h00, 32'h0000_0005, 4'b0101, 1'b0}, // R5 restart accepted
    {4'd5,  8'h04, 32'h0000_4859, 4'b0101, 1'b0},
    {4'd5,  8'h04, 32'h0000_1234, 4'b0101, 1'b0},
    {4'd5,  8'h04, 32'h0000_F27B, 4'b0101, 1'b0},
    {4'd5,  8'h00, 32'h0000_0002, 4'b0101, 1'b0}, // R5 corrupted key
    {4'd7,  8'h04, 32'h0000_4859, 4'b0101, 1'b0},
    {4'd7,  8'h04, 32'h0000_F27B, 4'b0101, 1'b0},
    {4'd7,  8'h00, 32'h0000_000F, 4'b0101, 1'b0}, // R7 reserved dropped
    {4'd7,  8'h00, 32'h0000_0002, 4'b0101, 1'b0}, // R7 still relocked
    {4'd8,  8'h08, 32'h000C_59D6, 4'b0101, 1'b0},
    {4'd8,  8'h0C, 32'h0000_0001, 4'b0101, 1'b1}, // R8 unlocked write
    {4'd8,  8'h08, 32'h0001_2345, 4'b0101, 1'b1},
    {4'd8,  8'h0C, 32'h0000_0000, 4'b0101, 1'b1}, // R8 relocked
    {4'd8,  8'h08, 32'hFFFC_59D6, 4'b0101, 1'b1},
    {4'd9,  8'h0C, 32'hFFFF_FFFE, 4'b0101, 1'b0}, // R9 bit 0 only
    {4'd4,  8'h04, 32'h0000_4859, 4'b0101, 1'b0},
    {4'd4,  8'h04, 32'h0000_F27B, 4'b0101, 1'b0},
    {4'd4,  8'h3C, 32'h0000_0000, 4'b0101, 1'b0},
    {4'd4,  8'h00, 32'h0000_0002, 4'b0101, 1'b0}, // R4 unmapped write
    {4'd2,  8'h04, 32'hABCD_4859, 4'b0101, 1'b0},
    {4'd2,  8'h04, 32'h0000_F27B, 4'b0101, 1'b0},
    {4'd2,  8'h00, 32'h0000_000A, 4'b1010, 1'b0}  // R2 upper key bits ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1;
    d = rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1", {28'd0, seq_sleep_en_o, tmr_sleep_en_o, pwr_mode_o}, 32'h1);
    check("R1", {31'd0, lf_clk_sel_o}, 32'h0);
    check("R1", 32'(lp_ctrl_o), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(8'h00, r); check("R1", r, 32'h1);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][44:37], VEC[i][36:5]);
      check($sformatf("R%0d", VEC[i][48:45]),
            {28'd0, seq_sleep_en_o, tmr_sleep_en_o, pwr_mode_o}, 32'(VEC[i][4:1]));
      check($sformatf("R%0d", VEC[i][48:45]), {31'd0, lf_clk_sel_o}, {31'd0, VEC[i][0]});
    end

    // R11 mode readback
    rd(8'h00, r); check("R11", r, 32'h0000_000A);
    // R10 key reads
    rd(8'h04, r); check("R10", r, 32'h0);
    rd(8'h08, r); check("R10", r, 32'h0);
    // R8 low-power control, level key still open
    wr(8'h10, 32'h0000_01A5);
    check("R8", 32'(lp_ctrl_o), 32'hA5);
    rd(8'h10, r); check("R8", r, 32'hA5);
    wr(8'h08, 32'h0);
    wr(8'h10, 32'h33);
    check("R8", 32'(lp_ctrl_o), 32'hA5);
    // R9 clock-select readback
    wr(8'h08, 32'h000C_59D6);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, r); check("R9", r, 32'h1);
    rd(8'h20, r); check("R10", r, 32'h0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1", {28'd0, seq_sleep_en_o, tmr_sleep_en_o, pwr_mode_o}, 32'h1);
    check("R1", {31'd0, lf_clk_sel_o}, 32'h0);
    check("R1", 32'(lp_ctrl_o), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    wr(8'h0C, 32'h1);
    check("R1", {31'd0, lf_clk_sel_o}, 32'h0);
    wr(8'h04, 32'h0000_F27B);
    wr(8'h00, 32'h0000_0002);
    check("R1", {28'd0, seq_sleep_en_o, tmr_sleep_en_o, pwr_mode_o}, 32'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule